// File: doc/BRIEF.md
# Dual-output serial flash read controller

This block sits on the host side of a serial NOR flash and pulls a run of bytes out of it with the dual-output fast read transaction. A request gives a 24-bit start address and a byte count. The controller selects the device and produces the serial clock by dividing the system clock by an even factor. It sends an opcode, the address and one dummy byte on a single line. It then turns the bus around and collects two bits per serial clock from two lines. Every finished byte is offered on a valid/ready output, tagged with its own array address.

The controller keeps its own copy of the byte address. That copy wraps at 24 bits in the same way the device's counter does, so a run that crosses the top of the array continues from address zero. If the consumer stops accepting bytes, the serial clock is frozen with the device still selected. No bit is dropped. After the last byte is taken the device is deselected, and the block stays busy for at least one more serial-clock period so that the minimum deselect time is met.

Top module: `dual_flash_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, dq0_en is 0, out_valid is 0, busy is 0 and req_ready is 1.
- R2: sclk idles low and toggles only while cs_n is 0. While it runs without a stall, one serial-clock period lasts DIV system clocks, where DIV is even and at least 2.
- R3: During the command phase, dq0_out carries 40 bits most significant bit first. These are the opcode (parameter, default 8'h3B), then req_addr[23:0], then eight zero dummy bits. dq0_out changes only while sclk is low, so it is stable at every rising edge.
- R4: dq0_en is 1 from selection until the first falling sclk edge after the 40th rising edge. It is 0 at every later rising edge of the transaction.
- R5: Each rising sclk edge after the 40th samples dq1_in and dq0_in as one pair. Four pairs make a byte, and the first pair gives bits 7 and 6. Within each pair dq1_in is the more significant bit (7,5,3,1) and dq0_in the less significant (6,4,2,0).
- R6: The k-th byte delivered (counting from 0) carries out_addr = (req_addr + k) mod 2^24. Its data is the device content at that address, so a run across 24'hFFFFFF continues at 24'h000000.
- R7: Exactly req_count bytes are delivered in one selection of the device. A request with req_count 0 is accepted and never selects the device.
- R8: While out_valid is 1 and out_ready is 0, out_data and out_addr hold, and sclk is frozen during the data phase. The run then resumes with no lost or repeated bits, so a transaction has exactly 40 + 4*req_count rising sclk edges.
- R9: req_ready equals not busy. busy stays 1 for at least DIV system clocks after cs_n rises.
- R10: cs_n stays 0 without a break from the start of a transaction to its end. sclk is 0 whenever cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 24 | First byte address |
| req_count | input | CNT_W | Number of bytes to read |
| out_valid | output | 1 | A read byte is offered |
| out_ready | input | 1 | Consumer takes the offered byte |
| out_data | output | 8 | Read byte |
| out_addr | output | 24 | Array address of the offered byte |
| busy | output | 1 | Transaction or deselect gap in progress |
| cs_n | output | 1 | Device select, active low |
| sclk | output | 1 | Serial clock |
| dq0_out | output | 1 | Command/address/dummy bit toward the device |
| dq0_en | output | 1 | Drive enable for line 0 |
| dq0_in | input | 1 | Line 0 as seen by the controller |
| dq1_in | input | 1 | Line 1 from the device |

## Verification
The read path is run under three consumer patterns: ready always high, pseudo-random ready, and ready given only once every few dozen cycles. Comparing the delivered bytes and the count of rising edges across these patterns shows whether the clock freeze loses or repeats a bit pair. A start just below the top of the array shows whether the address tag and the device data wrap together to zero. A zero-length request shows that nothing is selected. The command word captured by the flash model, the state of the drive enable at each edge and the measured period and deselect gap cover the bus turnaround and the clock timing.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    localparam int ADDR_W    = 24;
    localparam int CMD_BITS  = 40;
    localparam int DUMMY_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DRAIN,
        ST_HOLD,
        ST_GAP
    } fsm_t;

    typedef struct packed {
        logic [7:0]        data;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    function automatic logic [CMD_BITS-1:0] build_cmd(
        input logic [7:0]        op,
        input logic [ADDR_W-1:0] a
    );
        return {op, a, {DUMMY_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(1);
    endfunction
endpackage

// File: rtl/dfr_sclk_gen.sv
module dfr_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int HALF = DIV / 2;
    localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PH_W-1:0] ph;
    logic            term;

    assign term = en && (ph == PH_W'(HALF - 1));
    assign rise = term && !sclk;
    assign fall = term && sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            ph   <= '0;
        end else if (term) begin
            ph   <= '0;
            sclk <= ~sclk;
        end else begin
            ph   <= ph + PH_W'(1);
        end
    end

    // R8: a disabled generator keeps the serial clock level
    assert_gen_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sclk));
endmodule

// File: rtl/dfr_cmd_shift.sv
module dfr_cmd_shift
    import dfr_pkg::*;
#(
    parameter logic [7:0] OPCODE = 8'h3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              shift,
    output logic              bit_out
);
    logic [CMD_BITS-1:0] sr;

    assign bit_out = sr[CMD_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= build_cmd(OPCODE, addr);
        end else if (shift) begin
            sr <= {sr[CMD_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/dfr_pair_capture.sv
module dfr_pair_capture (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       strobe,
    input  logic       d_hi,
    input  logic       d_lo,
    output logic       done,
    output logic [7:0] byte_out
);
    logic [5:0] sr;
    logic [1:0] cnt;

    assign done     = strobe && (cnt == 2'd3);
    assign byte_out = {sr, d_hi, d_lo};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr  <= '0;
            cnt <= '0;
        end else if (strobe) begin
            sr  <= {sr[3:0], d_hi, d_lo};
            cnt <= cnt + 2'd1;
        end
    end
endmodule

// File: rtl/dual_flash_reader.sv
module dual_flash_reader
    import dfr_pkg::*;
#(
    parameter int         DIV    = 4,
    parameter int         CNT_W  = 16,
    parameter logic [7:0] OPCODE = 8'h3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              dq0_out,
    output logic              dq0_en,
    input  logic              dq0_in,
    input  logic              dq1_in
);
    localparam int BC_W = $clog2(CMD_BITS + 1);
    localparam int GC_W = $clog2(DIV) + 1;

    fsm_t              state;
    beat_t             beat_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem;
    logic [BC_W-1:0]   bitcnt;
    logic [GC_W-1:0]   gcnt;

    logic clk_en, rise, fall, start, cap_done, stalled;
    logic [7:0] cap_byte;

    assign start     = (state == ST_IDLE) && req_valid && (req_count != '0);
    assign stalled   = out_valid && !out_ready;
    assign clk_en    = (state == ST_CMD) || (state == ST_DRAIN) ||
                       ((state == ST_DATA) && !stalled);
    assign busy      = (state != ST_IDLE);
    assign req_ready = (state == ST_IDLE);
    assign out_data  = beat_q.data;
    assign out_addr  = beat_q.addr;

    dfr_sclk_gen #(.DIV(DIV)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    dfr_cmd_shift #(.OPCODE(OPCODE)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .addr    (req_addr),
        .shift   (fall && (state == ST_CMD)),
        .bit_out (dq0_out)
    );

    dfr_pair_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .strobe   (rise && (state == ST_DATA)),
        .d_hi     (dq1_in),
        .d_lo     (dq0_in),
        .done     (cap_done),
        .byte_out (cap_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            dq0_en    <= 1'b0;
            out_valid <= 1'b0;
            beat_q    <= '0;
            addr_q    <= '0;
            rem       <= '0;
            bitcnt    <= '0;
            gcnt      <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cs_n   <= 1'b0;
                        dq0_en <= 1'b1;
                        addr_q <= req_addr;
                        rem    <= req_count;
                        bitcnt <= '0;
                        state  <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        bitcnt <= bitcnt + BC_W'(1);
                        if (bitcnt == BC_W'(CMD_BITS - 1)) state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fall) dq0_en <= 1'b0;
                    if (cap_done) begin
                        out_valid   <= 1'b1;
                        beat_q.data <= cap_byte;
                        beat_q.addr <= addr_q;
                        addr_q      <= step_addr(addr_q);
                        rem         <= rem - CNT_W'(1);
                        if (rem == CNT_W'(1)) state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (fall) state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!out_valid || out_ready) begin
                        cs_n  <= 1'b1;
                        gcnt  <= '0;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    gcnt <= gcnt + GC_W'(1);
                    if (gcnt == GC_W'(DIV - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: serial clock rests low whenever the device is deselected
    assert_clk_low_deselected_R10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R3: command bit holds while the clock is high
    assert_cmd_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMD && sclk) |-> $stable(dq0_out));

    // R4: line 0 is never driven outside a transaction
    assert_no_drive_deselected_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dq0_en);

    // R8: offered byte holds under backpressure
    assert_hold_offer_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

    // R8: serial clock frozen under backpressure in the data phase
    assert_freeze_clock_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && out_valid && !out_ready) |=> $stable(sclk));

    // R7: bytes are offered only while the device is selected
    assert_offer_inside_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !cs_n);

    // R9: still busy right after deselect
    assert_gap_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> busy);
endmodule

// File: tb/dual_flash_reader_test.sv
`timescale 1ns/1ps
module dual_flash_reader_test;
    localparam int DIV = 6;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic out_ready = 1'b1;
    logic req_ready, out_valid, busy, cs_n, sclk, dq0_out, dq0_en;
    logic [7:0] out_data;
    logic [23:0] out_addr;
    logic fdq0 = 1'b0, fdq1 = 1'b0;
    logic dq0_line;

    always #10 clk = ~clk;

    assign dq0_line = dq0_en ? dq0_out : fdq0;

    dual_flash_reader #(.DIV(DIV), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
        .busy(busy), .cs_n(cs_n), .sclk(sclk), .dq0_out(dq0_out),
        .dq0_en(dq0_en), .dq0_in(dq0_line), .dq1_in(fdq1)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // flash model and monitors
    int mbit = 0, mpair = 0, rises = 0, en_err = 0, sclk_bad = 0, cs_rises = 0, cs_falls = 0;
    logic [39:0] mcmd = '0;
    logic [23:0] mptr = '0;
    realtime t1 = 0, t2 = 0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            rises++;
            if (rises == 1) t1 = $realtime;
            if (rises == 2) t2 = $realtime;
            if (mbit < 40) begin
                mcmd = {mcmd[38:0], dq0_out};
                if (!dq0_en) en_err++;
                mbit++;
                if (mbit == 40) mptr = mcmd[31:8];
            end else if (dq0_en) begin
                en_err++;
            end
        end else begin
            sclk_bad++;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && mbit >= 40) begin
            logic [7:0] b;
            b = mem_byte(mptr);
            fdq1 = b[7 - 2*mpair];
            fdq0 = b[6 - 2*mpair];
            mpair++;
            if (mpair == 4) begin
                mpair = 0;
                mptr  = mptr + 24'd1;
            end
        end
    end

    always @(posedge cs_n) begin
        mbit  = 0;
        mpair = 0;
        cs_rises++;
    end
    always @(negedge cs_n) cs_falls++;

    // consumer and collector
    int mode = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #3;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (mode == 0)      out_ready = 1'b1;
        else if (mode == 1) out_ready = lfsr[0];
        else                out_ready = (cyc % 23 == 0);
    end

    logic [7:0]  got_d [0:63];
    logic [23:0] got_a [0:63];
    int n_got = 0, gap_run = 0, last_gap = 0, rdy_busy = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (out_valid && out_ready && n_got < 64) begin
            got_d[n_got] = out_data;
            got_a[n_got] = out_addr;
            n_got++;
        end
        if (busy && req_ready) rdy_busy++;
        if (cs_n && busy) gap_run++;
        if (!busy && prev_busy) last_gap = gap_run;
        if (!busy) gap_run = 0;
        prev_busy = busy;
    end

    task automatic clear_mon();
        n_got = 0; rises = 0; en_err = 0; sclk_bad = 0;
        cs_rises = 0; cs_falls = 0; rdy_busy = 0; last_gap = 0;
    endtask

    task automatic issue(input logic [23:0] a, input int cnt);
        @(negedge clk);
        req_addr  = a;
        req_count = CW'(cnt);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1,     "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0,     "R1 sclk", sclk, 0);
        chk(dq0_en == 1'b0,   "R1 dq0_en", dq0_en, 0);
        chk(out_valid == 1'b0,"R1 out_valid", out_valid, 0);
        chk(busy == 1'b0,     "R1 busy", busy, 0);
        chk(req_ready == 1'b1,"R1 req_ready", req_ready, 1);
    endtask

    task automatic t_read(input logic [23:0] a, input int cnt, input int m, input string name);
        int w;
        mode = m;
        clear_mon();
        issue(a, cnt);
        w = 0;
        while (busy && w < 60000) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
        chk(n_got == cnt, {name, " R7 byte count"}, n_got, cnt);
        for (int k = 0; k < cnt && k < n_got; k++) begin
            logic [23:0] ea;
            ea = a + 24'(k);
            chk(got_d[k] == mem_byte(ea), {name, " R5 data"}, got_d[k], mem_byte(ea));
            chk(got_a[k] == ea, {name, " R6 address"}, got_a[k], ea);
        end
        chk(mcmd == {8'h3B, a, 8'h00}, {name, " R3 command word"}, mcmd, {8'h3B, a, 8'h00});
        chk(en_err == 0, {name, " R4 drive enable at edges"}, en_err, 0);
        chk(rises == 40 + 4*cnt, {name, " R8 rising edge count"}, rises, 40 + 4*cnt);
        chk(cs_rises == 1 && cs_falls == 1, {name, " R10 single selection"}, cs_rises, 1);
        chk(sclk_bad == 0, {name, " R2 clock while deselected"}, sclk_bad, 0);
        chk(last_gap >= DIV, {name, " R9 deselect gap"}, last_gap, DIV);
        chk(rdy_busy == 0, {name, " R9 req_ready while busy"}, rdy_busy, 0);
        if (m == 0) begin
            int per;
            per = int'(t2 - t1);
            chk(per == DIV*20, {name, " R2 serial clock period"}, per, DIV*20);
        end
    endtask

    task automatic t_zero();
        mode = 0;
        clear_mon();
        issue(24'h000100, 0);
        repeat (60) @(negedge clk);
        chk(cs_falls == 0, "R7 zero count selects nothing", cs_falls, 0);
        chk(busy == 1'b0 && req_ready == 1'b1, "R7 zero count leaves idle", busy, 0);
        chk(n_got == 0, "R7 zero count no bytes", n_got, 0);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read(24'h123456, 5, 0, "basic");
        t_read(24'hFFFFFE, 4, 0, "wrap");
        t_read(24'h00ABCD, 8, 1, "random_ready");
        t_read(24'hFFFFFF, 6, 2, "sparse_ready_wrap");
        t_zero();
        t_read(24'h000000, 1, 0, "single");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule